// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Clear-to-Send Gating

This block is the transmit half of an asynchronous serial port. A host writes a character into a one-entry holding register. At the next bit boundary the holding register's contents move into a frame sequencer. The sequencer sends a start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and one or two stop bits. Because the holding register refills while the sequencer is still sending, a host that writes again as soon as the holding-empty flag rises gets characters back to back with no idle bit between them.

Bit timing comes from an oversampling enable supplied by an external rate generator. Each serial bit lasts exactly sixteen of these enable pulses, whatever their spacing in clock cycles. A clear-to-send input controls only when a new character may start. A character already under way always runs to its last stop bit. A loop-mode input holds the serial line at Mark. Characters are still consumed at the normal rate in loop mode, and clear-to-send is ignored while it is set. The format controls (length, parity and stop count) are plain inputs. The sequencer samples them when a character is loaded.

Top module: `uart_tx_dbuf`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `txd` is 1 (Mark), `tbr_empty` is 1 and `tx_done` is 1.
- R2: A write (`wr_en` high for one clock) makes `tbr_empty` read 0 from the next cycle. `tx_done` falls no later than two cycles after the write.
- R3: `tbr_empty` rises in the same cycle that a held character begins its start bit. A character written at that moment follows the current one with no gap: its start bit falls exactly (1 + data bits + parity bit + stop bits) × 16 enable pulses after the previous start bit.
- R4: A frame on `txd` is a start bit (0), then data bits LSB first, then an optional parity bit, then stop bits (1). Each bit lasts exactly 16 pulses of `baud_tick`.
- R5: `char_len` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2, 3. Bits of `wr_data` above the selected length are ignored.
- R6: With `parity_en` = 1, the parity bit makes the total count of ones in data plus parity even when `parity_odd` = 0 and odd when `parity_odd` = 1. With `parity_en` = 0, no parity bit is sent.
- R7: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two.
- R8: While `cts` is 0 and `loop_mode` is 0, no character starts, `txd` stays 1 and `tbr_empty` stays 0 with a character pending. When `cts` returns to 1, the pending character is sent.
- R9: If `cts` falls after a character's start bit, that character completes unchanged.
- R10: While `loop_mode` is 1, `txd` is 1 one cycle later and stays 1. Characters are still taken from the holding register even when `cts` is 0.
- R11: `tx_done` is 1 only when the holding register is empty and no frame is in progress. It is 0 during a frame even after `tbr_empty` has risen.
- R12: Bit length is counted in `baud_tick` pulses, not clock cycles. With one pulse every 3 clocks, each bit lasts 48 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling enable, 16 pulses per serial bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| char_len | input | 2 | Data length code: 0 to 3 selects 5 to 8 bits |
| parity_en | input | 1 | Send a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits, 0 = one |
| cts | input | 1 | Clear to send, active high |
| loop_mode | input | 1 | Hold the line at Mark and ignore `cts` |
| txd | output | 1 | Serial data out, idle high |
| tbr_empty | output | 1 | Holding register is empty |
| tx_done | output | 1 | Holding register empty and no frame in progress |

## Verification
The hardest case to reach is the boundary cycle where the sequencer finishes a stop bit while the holding register was refilled in the middle of that frame. Only there does the zero-gap hand-off show.

The bench reaches it with two threads running in parallel. One thread decodes frames from the line. The other waits for the holding-empty flag to rise at the first start bit and writes the next character right away. The bench then compares the distance between the two start bits with the computed frame length.

A second hard case is clear-to-send falling mid-frame. It is reached the same way, by dropping `cts` from a parallel thread after the start bit has been seen.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_state_e;

endpackage

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic bit_end
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign bit_end = tick && (cnt == LAST);

  // R12
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LEN_W-1:0]  char_len,
  input  logic              load,
  output logic [DATA_W-1:0] data_q,
  output logic              empty_q
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < MIN_BITS + int'(char_len)) mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      if (wr_en) data_q <= wr_data & mask;
      if (wr_en) empty_q <= 1'b0;
      else if (load) empty_q <= 1'b1;
    end
  end

  // R2
  wr_clears_empty_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !empty_q);

  // R3
  load_sets_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !wr_en) |=> empty_q);

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_end,
  input  logic              hold_empty,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [LEN_W-1:0]  char_len,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              two_stop,
  input  logic              cts,
  input  logic              loop_mode,
  output logic              load,
  output logic              line_q,
  output logic              idle
);
  localparam int CNT_W = $clog2(DATA_W);

  tx_state_e         st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              par_q, par_d;
  logic              stop_more_q, stop_more_d;
  logic              fpar_q, fpar_d;
  logic              fodd_q, fodd_d;
  logic              fstop2_q, fstop2_d;
  logic              start_ok;
  logic              line_d;

  assign start_ok = !hold_empty && (cts || loop_mode);

  always_comb begin
    st_d        = st_q;
    sh_d        = sh_q;
    left_d      = left_q;
    par_d       = par_q;
    stop_more_d = stop_more_q;
    fpar_d      = fpar_q;
    fodd_d      = fodd_q;
    fstop2_d    = fstop2_q;
    load        = 1'b0;
    if (bit_end) begin
      unique case (st_q)
        TX_IDLE:  load = start_ok;
        TX_START: st_d = TX_DATA;
        TX_DATA: begin
          par_d = par_q ^ sh_q[0];
          sh_d  = sh_q >> 1;
          if (left_q == '0) begin
            st_d        = fpar_q ? TX_PAR : TX_STOP;
            stop_more_d = fstop2_q;
          end else begin
            left_d = left_q - 1'b1;
          end
        end
        TX_PAR: begin
          st_d        = TX_STOP;
          stop_more_d = fstop2_q;
        end
        TX_STOP: begin
          if (stop_more_q) stop_more_d = 1'b0;
          else if (start_ok) load = 1'b1;
          else st_d = TX_IDLE;
        end
        default: st_d = TX_IDLE;
      endcase
    end
    if (load) begin
      st_d        = TX_START;
      sh_d        = hold_data;
      left_d      = CNT_W'(char_len) + CNT_W'(MIN_BITS - 1);
      par_d       = 1'b0;
      stop_more_d = 1'b0;
      fpar_d      = parity_en;
      fodd_d      = parity_odd;
      fstop2_d    = two_stop;
    end
    unique case (st_d)
      TX_START: line_d = 1'b0;
      TX_DATA:  line_d = sh_d[0];
      TX_PAR:   line_d = par_d ^ fodd_d;
      default:  line_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= TX_IDLE;
      sh_q        <= '0;
      left_q      <= '0;
      par_q       <= 1'b0;
      stop_more_q <= 1'b0;
      fpar_q      <= 1'b0;
      fodd_q      <= 1'b0;
      fstop2_q    <= 1'b0;
      line_q      <= 1'b1;
    end else begin
      st_q        <= st_d;
      sh_q        <= sh_d;
      left_q      <= left_d;
      par_q       <= par_d;
      stop_more_q <= stop_more_d;
      fpar_q      <= fpar_d;
      fodd_q      <= fodd_d;
      fstop2_q    <= fstop2_d;
      line_q      <= line_d | loop_mode;
    end
  end

  assign idle = (st_q == TX_IDLE);

  // R4
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_end |=> $stable(st_q));

  // R9
  frame_runs_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == TX_DATA && !bit_end) |=> (st_q == TX_DATA));

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int OVS      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        char_len,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              two_stop,
  input  logic              cts,
  input  logic              loop_mode,
  output logic              txd,
  output logic              tbr_empty,
  output logic              tx_done
);
  localparam int LEN_W = 2;

  logic              bit_end;
  logic              load;
  logic [DATA_W-1:0] hold_data;
  logic              frame_idle;
  logic              done_q;

  uart_tx_bitclk #(.OVS(OVS)) u_bitclk (
    .clk     (clk),
    .rst     (rst),
    .tick    (baud_tick),
    .bit_end (bit_end)
  );

  uart_tx_hold #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .char_len (char_len),
    .load     (load),
    .data_q   (hold_data),
    .empty_q  (tbr_empty)
  );

  uart_tx_frame #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .bit_end    (bit_end),
    .hold_empty (tbr_empty),
    .hold_data  (hold_data),
    .char_len   (char_len),
    .parity_en  (parity_en),
    .parity_odd (parity_odd),
    .two_stop   (two_stop),
    .cts        (cts),
    .loop_mode  (loop_mode),
    .load       (load),
    .line_q     (txd),
    .idle       (frame_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b1;
    else     done_q <= tbr_empty && frame_idle;
  end

  assign tx_done = done_q;

  // R8
  cts_idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_idle && !cts) |=> txd);

  // R10
  loop_mark_chk: assert property (@(posedge clk) disable iff (rst)
    loop_mode |=> txd);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> frame_idle);

endmodule

// File: tb/uart_tx_dbuf_tb.sv
module uart_tx_dbuf_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] char_len = 2'd3;
  logic       parity_en = 1'b0;
  logic       parity_odd = 1'b0;
  logic       two_stop = 1'b0;
  logic       cts = 1'b1;
  logic       loop_mode = 1'b0;
  logic       txd, tbr_empty, tx_done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_div = 1;
  int tcnt = 0;
  bit finished = 0;

  uart_tx_dbuf u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .char_len(char_len), .parity_en(parity_en), .parity_odd(parity_odd),
    .two_stop(two_stop), .cts(cts), .loop_mode(loop_mode),
    .txd(txd), .tbr_empty(tbr_empty), .tx_done(tx_done)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(negedge clk);
      tcnt = (tcnt + 1) % tick_div;
      baud_tick = (tcnt == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int frame_bits(input int len, input bit pe, input bit s2);
    return 1 + len + (pe ? 1 : 0) + (s2 ? 2 : 1);
  endfunction

  // Decodes one frame from txd and compares it bit by bit with the expected frame.
  task automatic recv(input logic [7:0] b, input int len, input bit pe, input bit po,
                      input bit s2, input string req, output int t0);
    int n = 0;
    int bw = 16 * tick_div;
    logic [15:0] got = '0;
    logic [15:0] exp = '0;
    int k = 0;
    bit p = po;
    while (txd !== 1'b0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    t0 = cyc;
    repeat (bw / 2) @(negedge clk);
    got[k] = txd; exp[k] = 1'b0; k++;
    for (int i = 0; i < len; i++) begin
      repeat (bw) @(negedge clk);
      got[k] = txd; exp[k] = b[i]; p ^= b[i]; k++;
    end
    if (pe) begin
      repeat (bw) @(negedge clk);
      got[k] = txd; exp[k] = p; k++;
    end
    for (int i = 0; i < (s2 ? 2 : 1); i++) begin
      repeat (bw) @(negedge clk);
      got[k] = txd; exp[k] = 1'b1; k++;
    end
    check(n < 4000 && got == exp, req, int'(got), int'(exp));
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (tx_done !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(tx_done === 1'b1, req, tx_done, 1);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(txd === 1'b1 && tbr_empty === 1'b1 && tx_done === 1'b1, "R1 in reset",
          {txd, tbr_empty, tx_done}, 3'b111);
    rst = 1'b0;
    @(negedge clk);
    check(txd === 1'b1 && tbr_empty === 1'b1 && tx_done === 1'b1, "R1 after reset",
          {txd, tbr_empty, tx_done}, 3'b111);
  endtask

  task automatic t_basic;
    int t0;
    int n = 0;
    char_len = 2'd3; parity_en = 0; two_stop = 0;
    write_byte(8'hA5);
    check(tbr_empty === 1'b0, "R2 empty cleared", tbr_empty, 0);
    @(negedge clk);
    check(tx_done === 1'b0, "R2 done cleared", tx_done, 1'b0);
    recv(8'hA5, 8, 0, 0, 0, "R4 8N1 frame", t0);
    wait_done("R11 done after frame");
    // start bit width: data bit0 = 1 so the start bit is isolated
    write_byte(8'h01);
    while (txd !== 1'b0) @(negedge clk);
    check(tbr_empty === 1'b1, "R3 empty at start bit", tbr_empty, 1);
    check(tx_done === 1'b0, "R11 done low mid-frame", tx_done, 0);
    while (txd === 1'b0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == 16, "R4 bit lasts 16 ticks", n, 16);
    wait_done("R11 done after frame 2");
  endtask

  task automatic t_formats;
    int t0;
    char_len = 2'd0; parity_en = 1; parity_odd = 0; two_stop = 0;
    write_byte(8'hFF);
    recv(8'h1F, 5, 1, 0, 0, "R5 R6 5 bits even parity upper ignored", t0);
    wait_done("R11 done fmt1");
    char_len = 2'd1; parity_en = 1; parity_odd = 1; two_stop = 1;
    write_byte(8'hC6);
    recv(8'h06, 6, 1, 1, 1, "R6 R7 6 bits odd parity two stop", t0);
    wait_done("R11 done fmt2");
    char_len = 2'd2; parity_en = 0; two_stop = 1;
    write_byte(8'hB3);
    recv(8'h33, 7, 0, 0, 1, "R5 R7 7 bits two stop", t0);
    wait_done("R11 done fmt3");
    char_len = 2'd3; parity_en = 1; parity_odd = 0; two_stop = 0;
    write_byte(8'h81);
    recv(8'h81, 8, 1, 0, 0, "R6 8 bits even parity", t0);
    wait_done("R11 done fmt4");
  endtask

  task automatic t_back_to_back;
    int ta, tb;
    char_len = 2'd3; parity_en = 1; parity_odd = 1; two_stop = 0;
    write_byte(8'h3C);
    fork
      begin
        recv(8'h3C, 8, 1, 1, 0, "R3 first frame", ta);
        recv(8'hE7, 8, 1, 1, 0, "R3 second frame", tb);
      end
      begin
        while (tbr_empty !== 1'b1) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hE7;
        @(negedge clk);
        wr_en = 1'b0;
      end
    join
    check(tb - ta == frame_bits(8, 1, 0) * 16, "R3 no gap between frames",
          tb - ta, frame_bits(8, 1, 0) * 16);
    wait_done("R11 done after pair");
  endtask

  task automatic t_cts;
    int t0;
    bit line_ok = 1;
    char_len = 2'd3; parity_en = 0; two_stop = 0;
    cts = 1'b0;
    write_byte(8'h5A);
    repeat (100) begin
      @(negedge clk);
      if (txd !== 1'b1) line_ok = 0;
    end
    check(line_ok, "R8 line held Mark with cts low", line_ok, 1);
    check(tbr_empty === 1'b0, "R8 char kept pending", tbr_empty, 0);
    cts = 1'b1;
    recv(8'h5A, 8, 0, 0, 0, "R8 char sent after cts", t0);
    wait_done("R11 done after cts");
    write_byte(8'h96);
    fork
      recv(8'h96, 8, 0, 0, 0, "R9 frame completes after cts drop", t0);
      begin
        while (txd !== 1'b0) @(negedge clk);
        repeat (40) @(negedge clk);
        cts = 1'b0;
      end
    join
    wait_done("R11 done after cts drop");
    cts = 1'b1;
  endtask

  task automatic t_loop;
    bit line_ok = 1;
    int n = 0;
    loop_mode = 1'b1;
    cts = 1'b0;
    @(negedge clk);
    write_byte(8'h00);
    while (tbr_empty !== 1'b1 && n < 200) begin
      @(negedge clk);
      if (txd !== 1'b1) line_ok = 0;
      n++;
    end
    check(tbr_empty === 1'b1, "R10 char consumed with cts low", tbr_empty, 1);
    n = 0;
    while (tx_done !== 1'b1 && n < 400) begin
      @(negedge clk);
      if (txd !== 1'b1) line_ok = 0;
      n++;
    end
    check(line_ok, "R10 line Mark in loop mode", line_ok, 1);
    check(tx_done === 1'b1, "R10 frame ran in loop mode", tx_done, 1);
    loop_mode = 1'b0;
    cts = 1'b1;
  endtask

  task automatic t_gapped;
    int t0;
    int n = 0;
    tick_div = 3;
    char_len = 2'd3; parity_en = 0; two_stop = 0;
    repeat (4) @(negedge clk);
    write_byte(8'h6D);
    recv(8'h6D, 8, 0, 0, 0, "R12 frame with gapped ticks", t0);
    wait_done("R11 done gapped");
    write_byte(8'h01);
    while (txd !== 1'b0) @(negedge clk);
    while (txd === 1'b0 && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(n == 48, "R12 bit lasts 48 clocks", n, 48);
    wait_done("R11 done gapped 2");
    tick_div = 1;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_basic();
    t_formats();
    t_back_to_back();
    t_cts();
    t_loop();
    t_gapped();
    finish_run();
  end

endmodule